// File: doc/BRIEF.md
# Masked Configuration Space Register File

This block holds the 256-byte configuration space of one bus function. Software reaches it through a single access port. Each access carries a 32-bit address, a read/write flag, a byte count of 1, 2 or 4, and write data. The address names a bus number, a device/function number and a byte offset. The block only answers accesses that carry its own bus and device/function numbers, which are set as parameters. Identification fields are loaded from parameters at reset and cannot be written.

Every byte has a write mask, and a write changes only the masked bits of each byte. The mask is worked out from the byte's offset. Most header bytes are read-only. A few control fields are writable. The base address registers take their masks from the region sizes given as parameters, so software can size a region by writing all ones and reading the result back. The device-specific area above the header is fully writable.

Read data comes out little-endian one cycle after the access. A write that moves a base address, or that toggles the I/O or memory decode enable, raises a one-cycle pulse that downstream address decoders can use to reload their windows.

Top module: `cfg_space_regfile`

## Requirements
- R1: During and after reset, `rd_valid` and `remap_pulse` are low. The identification bytes are preset from parameters: vendor at 0x00–0x01, device at 0x02–0x03, revision at 0x08, class code at 0x09–0x0B and header type at 0x0E. All other bytes reset to zero, except byte 0 of an I/O base register, which resets to 0x01.
- R2: An access is ignored unless address bits [23:16] equal `BUS_NUM` and bits [15:8] (slot in the upper five bits, function in the lower three) equal `DEVFN`. An ignored read returns 0xFFFFFFFF, and an ignored write changes no byte.
- R3: Each written byte becomes (old & ~mask) | (new & mask). Byte k of the write data (bits 8k+7:8k) goes to offset base+k. This holds for unaligned offsets too.
- R4: A write that runs past offset 0xFF is cut short there. Lanes beyond 0xFF do not wrap to low offsets.
- R5: Below offset 0x40 the write masks are as follows. Byte 0x04 has mask 0x07 (I/O, memory and bus-master enables). Bytes 0x0C and 0x3C have mask 0xFF. The base-register and ROM bytes follow R7 and R8. Every other header byte is read-only. Bytes 0x40–0xFF have mask 0xFF.
- R6: A read returns the bytes from the base offset upward, little-endian, with the unused upper bytes as zero. A 4-byte read is legal at offsets up to 0xFC and a 2-byte read at offsets up to 0xFE. An illegal read, or any access whose length is not 1, 2 or 4, returns 0xFFFFFFFF and writes nothing.
- R7: Base register i sits at 0x10+4i and has write mask ~(size−1). A size of zero makes it read-only zero. The type bit 0 of an I/O register stays 1.
- R8: The expansion ROM register at 0x30 has write mask ~(ROM_SIZE−1) | 1, so its enable bit is writable.
- R9: `remap_pulse` is high for the cycle after a write that changes the value of any byte at 0x10–0x27, or bit 0 or bit 1 of byte 0x04. It is low after every other cycle.
- R10: `rd_valid` is high for exactly the cycle after each read access, and `rd_data` is valid in that cycle. A write never raises `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Bus [23:16], device/function [15:8], offset [7:0] |
| acc_len | input | 3 | Byte count: 1, 2 or 4 |
| acc_wdata | input | 32 | Write data, lowest byte to the lowest offset |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Little-endian read data |
| remap_pulse | output | 1 | One-cycle pulse after an address-affecting write |

## Verification
The bench builds the block with bus 0x03 and device/function 0x2A (slot 5, function 2). These values let it tell a near-miss on either field apart from a hit. The region sizes are 4 KiB for memory base register 0, 32 bytes for I/O base register 1, zero for registers 2 to 5, and 2 KiB for the ROM. Together they cover a memory mask, an I/O mask that keeps its type bit, an unimplemented register and the writable ROM enable. The accesses near offsets 0xFC–0xFF exercise the read limits and the write cut-off at the top of the space.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  localparam logic [7:0] OFF_VENDOR  = 8'h00;
  localparam logic [7:0] OFF_DEVICE  = 8'h02;
  localparam logic [7:0] OFF_CMD     = 8'h04;
  localparam logic [7:0] OFF_REV     = 8'h08;
  localparam logic [7:0] OFF_CLASS   = 8'h09;
  localparam logic [7:0] OFF_LINESZ  = 8'h0C;
  localparam logic [7:0] OFF_HDR     = 8'h0E;
  localparam logic [7:0] BAR_FIRST   = 8'h10;
  localparam logic [7:0] BAR_WIN_END = 8'h28;
  localparam logic [7:0] OFF_ROM     = 8'h30;
  localparam logic [7:0] OFF_IRQLINE = 8'h3C;
  localparam logic [7:0] HDR_END     = 8'h40;
  localparam logic [7:0] CMD_WMASK   = 8'h07;
  localparam logic [1:0] CMD_DECODE  = 2'b11;

  localparam int LANES = 4;

  typedef struct packed {
    logic                  valid;
    logic                  write;
    logic                  hit;
    logic                  rd_ok;
    logic [LANES-1:0]      lane_en;
    logic [LANES-1:0][7:0] lane_off;
  } acc_t;

  function automatic logic [31:0] size_to_mask(input logic [31:0] sz);
    return (sz == 32'd0) ? 32'd0 : ~(sz - 32'd1);
  endfunction

endpackage

// File: rtl/cfgs_decode.sv
module cfgs_decode
  import cfgs_pkg::*;
#(
  parameter logic [7:0] BUS_NUM = 8'h00,
  parameter logic [7:0] DEVFN   = 8'h08
) (
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [31:0] acc_addr,
  input  logic [2:0]  acc_len,
  output acc_t        acc
);

  logic [7:0] base;
  logic       len_ok;
  logic       addr_unused;

  assign base        = acc_addr[7:0];
  assign addr_unused = ^acc_addr[31:24];
  assign len_ok      = (acc_len == 3'd1) || (acc_len == 3'd2) || (acc_len == 3'd4);

  always_comb begin
    acc.valid = acc_valid;
    acc.write = acc_write;
    acc.hit   = acc_valid && len_ok &&
                (acc_addr[23:16] == BUS_NUM) && (acc_addr[15:8] == DEVFN);
    acc.rd_ok = (acc_len == 3'd1) ||
                ((acc_len == 3'd2) && (base <= 8'hFE)) ||
                ((acc_len == 3'd4) && (base <= 8'hFC));
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [8:0] sum;
    assign sum             = {1'b0, base} + 9'(k);
    assign acc.lane_off[k] = sum[7:0];
    assign acc.lane_en[k]  = acc.hit && (3'(k) < acc_len) && !sum[8];
  end

endmodule

// File: rtl/cfgs_wmask.sv
module cfgs_wmask
  import cfgs_pkg::*;
#(
  parameter int                             NUM_BARS  = 6,
  parameter logic [NUM_BARS-1:0][31:0]      BAR_SIZE  = '0,
  parameter logic [31:0]                    ROM_SIZE  = 32'h800
) (
  input  logic [LANES-1:0][7:0] lane_off,
  output logic [LANES-1:0][7:0] lane_mask
);

  function automatic logic [7:0] byte_mask(input logic [7:0] o);
    logic [7:0]  m;
    logic [31:0] w;
    m = 8'h00;
    w = 32'd0;
    if (o >= HDR_END) begin
      m = 8'hFF;
    end else if (o == OFF_CMD) begin
      m = CMD_WMASK;
    end else if ((o == OFF_LINESZ) || (o == OFF_IRQLINE)) begin
      m = 8'hFF;
    end else begin
      for (int i = 0; i < NUM_BARS; i++) begin
        if (o[7:2] == BAR_FIRST[7:2] + 6'(i)) begin
          w = size_to_mask(BAR_SIZE[i]);
          m = w[{o[1:0], 3'b000} +: 8];
        end
      end
      if (o[7:2] == OFF_ROM[7:2]) begin
        w = size_to_mask(ROM_SIZE) | 32'd1;
        m = w[{o[1:0], 3'b000} +: 8];
      end
    end
    return m;
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_mask
    assign lane_mask[k] = byte_mask(lane_off[k]);
  end

endmodule

// File: rtl/cfgs_store.sv
module cfgs_store
  import cfgs_pkg::*;
#(
  parameter logic [15:0]           VENDOR_ID  = 16'h0000,
  parameter logic [15:0]           DEVICE_ID  = 16'h0000,
  parameter logic [7:0]            REV_ID     = 8'h00,
  parameter logic [23:0]           CLASS_CODE = 24'h000000,
  parameter logic [7:0]            HDR_TYPE   = 8'h00,
  parameter int                    NUM_BARS   = 6,
  parameter logic [NUM_BARS-1:0]   BAR_IS_IO  = '0,
  parameter int                    SPACE_BYTES = 256
) (
  input  logic                  clk,
  input  logic                  rst,
  input  acc_t                  acc,
  input  logic [31:0]           wdata,
  input  logic [LANES-1:0][7:0] lane_mask,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  output logic                  remap_pulse
);

  logic [7:0] mem [SPACE_BYTES];

  logic [LANES-1:0][7:0] old_b;
  logic [LANES-1:0][7:0] new_b;
  logic [LANES-1:0]      wr_en;
  logic [LANES-1:0]      remap_hit;
  logic [31:0]           rd_word;
  logic                  is_read;

  function automatic logic [7:0] init_byte(input logic [7:0] o);
    logic [7:0] b;
    b = 8'h00;
    case (o)
      OFF_VENDOR:         b = VENDOR_ID[7:0];
      OFF_VENDOR + 8'd1:  b = VENDOR_ID[15:8];
      OFF_DEVICE:         b = DEVICE_ID[7:0];
      OFF_DEVICE + 8'd1:  b = DEVICE_ID[15:8];
      OFF_REV:            b = REV_ID;
      OFF_CLASS:          b = CLASS_CODE[7:0];
      OFF_CLASS + 8'd1:   b = CLASS_CODE[15:8];
      OFF_CLASS + 8'd2:   b = CLASS_CODE[23:16];
      OFF_HDR:            b = HDR_TYPE;
      default:            b = 8'h00;
    endcase
    for (int i = 0; i < NUM_BARS; i++) begin
      if (BAR_IS_IO[i] && (o == BAR_FIRST + 8'(4 * i))) b = 8'h01;
    end
    return b;
  endfunction

  assign is_read = acc.valid && !acc.write;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [7:0] diff;
    logic       in_bar;
    assign old_b[k]  = mem[acc.lane_off[k]];
    assign new_b[k]  = (old_b[k] & ~lane_mask[k]) | (wdata[8*k +: 8] & lane_mask[k]);
    assign wr_en[k]  = acc.valid && acc.write && acc.lane_en[k];
    assign diff      = old_b[k] ^ new_b[k];
    assign in_bar    = (acc.lane_off[k] >= BAR_FIRST) && (acc.lane_off[k] < BAR_WIN_END);
    assign remap_hit[k] = wr_en[k] &&
                          ((in_bar && (diff != 8'h00)) ||
                           ((acc.lane_off[k] == OFF_CMD) && ((diff[1:0] & CMD_DECODE) != 2'b00)));
    assign rd_word[8*k +: 8] = acc.lane_en[k] ? old_b[k] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      remap_pulse <= 1'b0;
      for (int i = 0; i < SPACE_BYTES; i++) mem[i] <= init_byte(8'(i));
    end else begin
      rd_valid    <= is_read;
      remap_pulse <= |remap_hit;
      if (is_read) rd_data <= (acc.hit && acc.rd_ok) ? rd_word : 32'hFFFF_FFFF;
      for (int k = 0; k < LANES; k++) begin
        if (wr_en[k]) mem[acc.lane_off[k]] <= new_b[k];
      end
    end
  end

endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
  import cfgs_pkg::*;
#(
  parameter logic [7:0]                BUS_NUM    = 8'h00,
  parameter logic [7:0]                DEVFN      = 8'h08,
  parameter logic [15:0]               VENDOR_ID  = 16'h1234,
  parameter logic [15:0]               DEVICE_ID  = 16'h5678,
  parameter logic [7:0]                REV_ID     = 8'h01,
  parameter logic [23:0]               CLASS_CODE = 24'h020000,
  parameter logic [7:0]                HDR_TYPE   = 8'h00,
  parameter int                        NUM_BARS   = 6,
  parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE   = {32'h0, 32'h0, 32'h0, 32'h0, 32'h20, 32'h1000},
  parameter logic [NUM_BARS-1:0]       BAR_IS_IO  = 6'b000010,
  parameter logic [31:0]               ROM_SIZE   = 32'h800
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [31:0] acc_addr,
  input  logic [2:0]  acc_len,
  input  logic [31:0] acc_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        remap_pulse
);

  localparam int SPACE_BYTES = 256;

  acc_t                  acc;
  logic [LANES-1:0][7:0] lane_mask;

  cfgs_decode #(.BUS_NUM(BUS_NUM), .DEVFN(DEVFN)) u_decode (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_len   (acc_len),
    .acc       (acc)
  );

  cfgs_wmask #(.NUM_BARS(NUM_BARS), .BAR_SIZE(BAR_SIZE), .ROM_SIZE(ROM_SIZE)) u_wmask (
    .lane_off  (acc.lane_off),
    .lane_mask (lane_mask)
  );

  cfgs_store #(
    .VENDOR_ID   (VENDOR_ID),
    .DEVICE_ID   (DEVICE_ID),
    .REV_ID      (REV_ID),
    .CLASS_CODE  (CLASS_CODE),
    .HDR_TYPE    (HDR_TYPE),
    .NUM_BARS    (NUM_BARS),
    .BAR_IS_IO   (BAR_IS_IO),
    .SPACE_BYTES (SPACE_BYTES)
  ) u_store (
    .clk         (clk),
    .rst         (rst),
    .acc         (acc),
    .wdata       (acc_wdata),
    .lane_mask   (lane_mask),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .remap_pulse (remap_pulse)
  );

endmodule

// File: rtl/cfgs_chk.sv
module cfgs_chk #(
  parameter logic [7:0] BUS_NUM = 8'h00,
  parameter logic [7:0] DEVFN   = 8'h08
) (
  input logic        clk,
  input logic        rst,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [31:0] acc_addr,
  input logic [2:0]  acc_len,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        remap_pulse
);

  logic rd_req, len_good, match;
  assign rd_req   = acc_valid && !acc_write;
  assign len_good = (acc_len == 3'd1) || (acc_len == 3'd2) || (acc_len == 3'd4);
  assign match    = (acc_addr[23:16] == BUS_NUM) && (acc_addr[15:8] == DEVFN);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!rd_valid && !remap_pulse));

  // R10
  rd_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  // R10
  rd_only_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req));

  // R9
  remap_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    remap_pulse |-> $past(acc_valid && acc_write));

  // R2
  miss_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !match) |=> (rd_data == 32'hFFFF_FFFF));

  // R6
  bad_len_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !len_good) |=> (rd_data == 32'hFFFF_FFFF));

  // R6
  byte_read_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && match && acc_len == 3'd1) |=> (rd_data[31:8] == 24'd0));

endmodule

bind cfg_space_regfile cfgs_chk #(.BUS_NUM(BUS_NUM), .DEVFN(DEVFN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_addr    (acc_addr),
  .acc_len     (acc_len),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .remap_pulse (remap_pulse)
);

// File: tb/sim_cfg_space_regfile.sv
module sim_cfg_space_regfile;

  localparam int          CLK_PERIOD = 10;
  localparam logic [7:0]  BUS   = 8'h03;
  localparam logic [7:0]  DEVFN = 8'h2A;
  localparam logic [15:0] VID   = 16'hA5C3;
  localparam logic [15:0] DID   = 16'h7E21;
  localparam logic [7:0]  REV   = 8'h04;
  localparam logic [23:0] CLS   = 24'h028000;
  localparam logic [7:0]  HDR   = 8'h00;
  localparam logic [31:0] ROMSZ = 32'h800;
  localparam logic [5:0]  BIO   = 6'b000010;
  localparam logic [31:0] BSZ [6] = '{32'h1000, 32'h20, 32'h0, 32'h0, 32'h0, 32'h0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_len = 3'd4;
  logic [31:0] acc_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        remap_pulse;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] mdl [256];
  bit          pend_v = 0, pend_r = 0, exp_v = 0, exp_r = 0;
  logic [31:0] pend_d = '0, exp_d = '0;
  string       pend_tag = "idle", exp_tag = "idle";

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_space_regfile #(
    .BUS_NUM(BUS), .DEVFN(DEVFN), .VENDOR_ID(VID), .DEVICE_ID(DID), .REV_ID(REV),
    .CLASS_CODE(CLS), .HDR_TYPE(HDR), .NUM_BARS(6),
    .BAR_SIZE({32'h0, 32'h0, 32'h0, 32'h0, 32'h20, 32'h1000}),
    .BAR_IS_IO(BIO), .ROM_SIZE(ROMSZ)
  ) u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_len(acc_len), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .remap_pulse(remap_pulse)
  );

  function automatic logic [7:0] exp_mask(input int o);
    logic [31:0] w;
    if (o >= 64) return 8'hFF;
    if (o == 4) return 8'h07;
    if (o == 12 || o == 60) return 8'hFF;
    if (o >= 16 && o < 40) begin
      w = (BSZ[(o-16)/4] == 0) ? 32'd0 : ~(BSZ[(o-16)/4] - 32'd1);
      return 8'(w >> (8 * (o % 4)));
    end
    if (o >= 48 && o < 52) begin
      w = ~(ROMSZ - 32'd1) | 32'd1;
      return 8'(w >> (8 * (o % 4)));
    end
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    mdl[0] = VID[7:0];  mdl[1] = VID[15:8];
    mdl[2] = DID[7:0];  mdl[3] = DID[15:8];
    mdl[8] = REV;
    mdl[9] = CLS[7:0];  mdl[10] = CLS[15:8]; mdl[11] = CLS[23:16];
    mdl[14] = HDR;
    for (int i = 0; i < 6; i++) if (BIO[i]) mdl[16 + 4*i] = 8'h01;
  endtask

  task automatic model(input bit w, input logic [31:0] a, input logic [2:0] len,
                       input logic [31:0] d, output bit ev, output logic [31:0] ed,
                       output bit er);
    int off;
    int o;
    bit hit;
    logic [7:0] m, nb;
    off = int'(a[7:0]);
    hit = (a[23:16] == BUS) && (a[15:8] == DEVFN) && (len == 1 || len == 2 || len == 4);
    ev = !w; ed = 32'hFFFF_FFFF; er = 0;
    if (w && hit) begin
      for (int k = 0; k < int'(len); k++) begin
        o = off + k;
        if (o <= 255) begin
          m  = exp_mask(o);
          nb = (mdl[o] & ~m) | (d[8*k +: 8] & m);
          if (o >= 16 && o < 40 && nb != mdl[o]) er = 1;
          if (o == 4 && ((nb ^ mdl[o]) & 8'h03) != 0) er = 1;
          mdl[o] = nb;
        end
      end
    end
    if (!w && hit && (len == 1 || (len == 2 && off <= 254) || (len == 4 && off <= 252))) begin
      ed = '0;
      for (int k = 0; k < int'(len); k++) ed[8*k +: 8] = mdl[off + k];
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    exp_v   <= pend_v;
    exp_d   <= pend_d;
    exp_r   <= pend_r;
    exp_tag <= pend_tag;
  end

  // cycle-by-cycle comparison against the reference model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(rd_valid === exp_v, {exp_tag, " rd_valid (R10)"}, 32'(rd_valid), 32'(exp_v));
      if (exp_v) check(rd_data === exp_d, {exp_tag, " rd_data"}, rd_data, exp_d);
      check(remap_pulse === exp_r, {exp_tag, " remap (R9)"}, 32'(remap_pulse), 32'(exp_r));
    end
  end

  task automatic acc(input bit w, input logic [7:0] bus, input logic [7:0] df,
                     input logic [7:0] off, input logic [2:0] len, input logic [31:0] d,
                     input string tag);
    bit ev, er;
    logic [31:0] ed;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = {8'h00, bus, df, off};
    acc_len = len; acc_wdata = d;
    model(w, acc_addr, len, d, ev, ed, er);
    pend_v = ev; pend_d = ed; pend_r = er; pend_tag = tag;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    pend_v = 0; pend_r = 0; pend_tag = "idle";
  endtask

  task automatic rd_chk(input logic [7:0] bus, input logic [7:0] df, input logic [7:0] off,
                        input logic [2:0] len, input logic [31:0] expv, input string tag);
    acc(0, bus, df, off, len, 32'd0, tag);
    idle();
    check(rd_valid === 1'b1 && rd_data === expv, tag, rd_data, expv);
  endtask

  task automatic wr_chk(input logic [7:0] bus, input logic [7:0] df, input logic [7:0] off,
                        input logic [2:0] len, input logic [31:0] d, input bit exp_remap,
                        input string tag);
    acc(1, bus, df, off, len, d, tag);
    idle();
    check(remap_pulse === exp_remap, tag, 32'(remap_pulse), 32'(exp_remap));
    check(rd_valid === 1'b0, "R10 write gives no rd_valid", 32'(rd_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(rd_valid === 1'b0 && remap_pulse === 1'b0, "R1 outputs after reset",
          {30'd0, rd_valid, remap_pulse}, 32'd0);

    // R1 identification and reset values
    rd_chk(BUS, DEVFN, 8'h00, 3'd4, {DID, VID}, "R1 ids");
    rd_chk(BUS, DEVFN, 8'h08, 3'd4, {CLS, REV}, "R1 class/rev");
    rd_chk(BUS, DEVFN, 8'h04, 3'd4, 32'h0, "R1 command zero");
    rd_chk(BUS, DEVFN, 8'h14, 3'd4, 32'h1, "R7 io bar type");

    // R5 header masks, R9 command decode bits
    wr_chk(BUS, DEVFN, 8'h04, 3'd2, 32'hFFFF, 1'b1, "R9 cmd enable");
    rd_chk(BUS, DEVFN, 8'h04, 3'd2, 32'h0007, "R5 cmd mask");
    wr_chk(BUS, DEVFN, 8'h04, 3'd1, 32'h00, 1'b1, "R9 cmd clear");
    wr_chk(BUS, DEVFN, 8'h04, 3'd1, 32'h04, 1'b0, "R9 master only");
    rd_chk(BUS, DEVFN, 8'h04, 3'd1, 32'h04, "R5 master bit");
    wr_chk(BUS, DEVFN, 8'h00, 3'd4, 32'hFFFF_FFFF, 1'b0, "R5 ids ro");
    rd_chk(BUS, DEVFN, 8'h00, 3'd4, {DID, VID}, "R5 ids kept");
    wr_chk(BUS, DEVFN, 8'h0C, 3'd4, 32'hFFFF_FFFF, 1'b0, "R5 line size");
    rd_chk(BUS, DEVFN, 8'h0C, 3'd4, 32'h0000_00FF, "R5 line size only");
    wr_chk(BUS, DEVFN, 8'h3C, 3'd4, 32'hFFFF_FFFF, 1'b0, "R5 irq line");
    rd_chk(BUS, DEVFN, 8'h3C, 3'd4, 32'h0000_00FF, "R5 irq line only");

    // R7 base registers, R8 ROM
    wr_chk(BUS, DEVFN, 8'h10, 3'd4, 32'hFFFF_FFFF, 1'b1, "R9 bar0 move");
    rd_chk(BUS, DEVFN, 8'h10, 3'd4, 32'hFFFF_F000, "R7 bar0 size");
    wr_chk(BUS, DEVFN, 8'h10, 3'd4, 32'hFFFF_FFFF, 1'b0, "R9 bar0 same");
    wr_chk(BUS, DEVFN, 8'h14, 3'd4, 32'hFFFF_FFFF, 1'b1, "R9 bar1 move");
    rd_chk(BUS, DEVFN, 8'h14, 3'd4, 32'hFFFF_FFE1, "R7 io bar size");
    wr_chk(BUS, DEVFN, 8'h18, 3'd4, 32'hFFFF_FFFF, 1'b0, "R7 empty bar");
    rd_chk(BUS, DEVFN, 8'h18, 3'd4, 32'h0, "R7 empty bar zero");
    wr_chk(BUS, DEVFN, 8'h30, 3'd4, 32'hFFFF_FFFF, 1'b0, "R8 rom write");
    rd_chk(BUS, DEVFN, 8'h30, 3'd4, 32'hFFFF_F801, "R8 rom size+enable");
    wr_chk(BUS, DEVFN, 8'h30, 3'd1, 32'h00, 1'b0, "R8 rom disable");
    rd_chk(BUS, DEVFN, 8'h30, 3'd4, 32'hFFFF_F800, "R8 rom enable cleared");

    // R3 lane order, R6 little-endian reads
    wr_chk(BUS, DEVFN, 8'h40, 3'd4, 32'h1122_3344, 1'b0, "R3 dev area");
    rd_chk(BUS, DEVFN, 8'h41, 3'd1, 32'h33, "R6 byte read");
    rd_chk(BUS, DEVFN, 8'h42, 3'd2, 32'h1122, "R6 half read");
    wr_chk(BUS, DEVFN, 8'h7E, 3'd4, 32'hA1B2_C3D4, 1'b0, "R3 unaligned");
    rd_chk(BUS, DEVFN, 8'h7C, 3'd4, 32'hC3D4_0000, "R3 unaligned low");
    rd_chk(BUS, DEVFN, 8'h80, 3'd2, 32'hA1B2, "R3 unaligned high");

    // R4 truncation at top
    wr_chk(BUS, DEVFN, 8'hFE, 3'd4, 32'hAABB_CCDD, 1'b0, "R4 top write");
    rd_chk(BUS, DEVFN, 8'hFE, 3'd2, 32'hCCDD, "R4 top bytes");
    rd_chk(BUS, DEVFN, 8'h00, 3'd4, {DID, VID}, "R4 no wrap");
    rd_chk(BUS, DEVFN, 8'hFC, 3'd4, 32'hCCDD_0000, "R6 last word");

    // R6 illegal reads and lengths
    rd_chk(BUS, DEVFN, 8'hFD, 3'd4, 32'hFFFF_FFFF, "R6 word past end");
    rd_chk(BUS, DEVFN, 8'hFF, 3'd2, 32'hFFFF_FFFF, "R6 half past end");
    rd_chk(BUS, DEVFN, 8'hFF, 3'd1, 32'hCC, "R6 last byte");
    rd_chk(BUS, DEVFN, 8'h40, 3'd3, 32'hFFFF_FFFF, "R6 bad len read");
    wr_chk(BUS, DEVFN, 8'h40, 3'd3, 32'hFFFF_FFFF, 1'b0, "R6 bad len write");
    rd_chk(BUS, DEVFN, 8'h40, 3'd4, 32'h1122_3344, "R6 bad len no write");

    // R2 address match
    wr_chk(8'h04, DEVFN, 8'h40, 3'd4, 32'h0, 1'b0, "R2 other bus write");
    wr_chk(BUS, 8'h2B, 8'h40, 3'd4, 32'h0, 1'b0, "R2 other fn write");
    wr_chk(BUS, 8'h22, 8'h10, 3'd4, 32'h0, 1'b0, "R2 other slot bar");
    rd_chk(BUS, DEVFN, 8'h40, 3'd4, 32'h1122_3344, "R2 unchanged");
    rd_chk(8'h02, DEVFN, 8'h00, 3'd4, 32'hFFFF_FFFF, "R2 other bus read");
    rd_chk(BUS, 8'h32, 8'h00, 3'd4, 32'hFFFF_FFFF, "R2 other slot read");

    // R10 back-to-back reads
    acc(0, BUS, DEVFN, 8'h40, 3'd1, 32'h0, "R10 b2b a");
    acc(0, BUS, DEVFN, 8'h41, 3'd1, 32'h0, "R10 b2b b");
    acc(1, BUS, DEVFN, 8'h44, 3'd4, 32'h5566_7788, "R10 b2b w");
    acc(0, BUS, DEVFN, 8'h44, 3'd4, 32'h0, "R10 b2b c");
    idle();

    // R3 mixed traffic checked each cycle by the model
    for (int n = 0; n < 400; n++) begin
      logic [2:0] l;
      logic [7:0] b;
      case ($urandom % 4)
        0: l = 3'd1;
        1: l = 3'd2;
        2: l = 3'd4;
        default: l = 3'd3;
      endcase
      b = (($urandom % 8) == 0) ? 8'h05 : BUS;
      acc(1'($urandom % 2), b, DEVFN, 8'($urandom), l, $urandom, "R3 mixed");
      if (($urandom % 3) == 0) idle();
    end
    idle();
    idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule